// File: doc/BRIEF.md
# Line Read Buffer for a 16-bit Memory Port

This block sits between a processor-side read port, which issues 16-bit and 32-bit reads, and an external memory port that is only 16 bits wide. It keeps one 64-bit line together with a valid flag and the line address of the data it holds. A read that finds its data in the line completes in the same cycle. Any other buffered read holds the requester. The block then fetches the whole 8-byte-aligned line as four 16-bit beats, stores it, and answers from the refreshed line.

Reads carrying the non-bufferable attribute are meant for device or peripheral space. They skip the line altogether: they go out as one beat for a halfword or two beats for a word, and the stored line is left as it was. A write-notification input reports the line address of every write made elsewhere in the system. A write that lands on the held line, or on the line that is being fetched, makes sure stale data is never returned.

The requester holds `cpu_req` and its attributes until `cpu_done` is high at a rising edge. On the memory side, each beat is a request/ready handshake.

Top module: `narrow_line_buf`

## Requirements
- R1: Reset clears the valid flag and holds `mem_req` and `cpu_done` low. The first buffered read after reset therefore misses, even for a line that was held before the reset.
- R2: A buffered read of either width that misses issues exactly four beats. The beat addresses run in ascending order from the 8-byte-aligned line base: base, base+2, base+4, base+6.
- R3: A buffered read is a hit when the flag is valid and `cpu_addr[31:3]` equals the stored line address. A hit raises `cpu_done` in the cycle of the request and issues no beat.
- R4: Beat k is stored in line bits [16k+15:16k]. A word read (`cpu_wide`=1) returns line bits [63:32] when `cpu_addr[2]` is 1 and bits [31:0] otherwise, and `cpu_addr[1:0]` is ignored. A halfword read returns the halfword selected by `cpu_addr[2:1]` in `cpu_rdata[15:0]` with bits [31:16] zero, and `cpu_addr[0]` is ignored.
- R5: During a fetch, `cpu_done` stays low until the fourth beat's handshake. The read then completes in the cycle right after that handshake, and no partly fetched line ever yields a hit.
- R6: A read at the next 8-byte boundary, such as 0x48 after reads at 0x40 and 0x44, misses and fetches its own line.
- R7: A read with `cpu_nobuf`=1 never hits. A halfword read issues one beat at the halfword-aligned address. A word read issues two beats, low halfword first, at the word-aligned address. `cpu_done` rises in the cycle after the last handshake, and the stored line and its valid flag stay unchanged.
- R8: A `wr_vld` pulse whose `wr_line` equals the held line address clears the valid flag. A pulse for any other line has no effect.
- R9: A matching `wr_vld` during a fetch stops that fetch from marking the line valid, so the read fetches the line again. A matching `wr_vld` in the same cycle as a hit lets that hit return the old data and then clears the flag.
- R10: While `mem_req` is high and `mem_ready` is low, `mem_req` stays high and `mem_addr` stays stable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Read request, held until done |
| cpu_addr | input | AW | Byte address of the read |
| cpu_wide | input | 1 | 1 = 32-bit read, 0 = 16-bit read |
| cpu_nobuf | input | 1 | 1 = device space, bypass the line |
| cpu_done | output | 1 | Read completes at this edge |
| cpu_rdata | output | 32 | Read data, valid with cpu_done |
| wr_vld | input | 1 | A write to memory happened this cycle |
| wr_line | input | AW-3 | Line address (byte address bits above 2) of that write |
| mem_req | output | 1 | Beat request to external memory |
| mem_addr | output | AW | Byte address of the halfword beat |
| mem_ready | input | 1 | Beat accepted, data valid |
| mem_rdata | input | 16 | Beat read data |

## Verification
Two events can fall in the same cycle: a write notification and a line update. The update is either a hit served from the line or a fetch reaching or nearing its final beat. The bench provokes the first by raising the write pulse in the very cycle of a hit request. It then expects the old data with no beat, followed by a four-beat miss that returns the newly written data. It provokes the second by writing to the memory model and notifying a line while that line's fetch is under way. The read must then take eight beats and return only the new contents.

// File: rtl/nlb_pkg.sv
`timescale 1ns/1ps
package nlb_pkg;
  localparam int unsigned LINE_BYTES = 8;
  localparam int unsigned BEAT_W     = 16;
  localparam int unsigned LINE_W     = LINE_BYTES * 8;
  localparam int unsigned NBEATS     = LINE_W / BEAT_W;
  localparam int unsigned OFF_W      = $clog2(LINE_BYTES);
  localparam int unsigned BIDX_W     = $clog2(NBEATS);

  typedef enum logic [1:0] {SQ_IDLE, SQ_FILL, SQ_BYP, SQ_RESP} sq_state_e;

  // sel = address bits [OFF_W-1:1]; word picks by its top bit, halfword by all
  function automatic logic [31:0] pick_data(input logic [LINE_W-1:0] line,
                                            input logic [OFF_W-2:0] sel,
                                            input logic wide);
    logic [31:0] r;
    if (wide) r = line[32*int'(sel[OFF_W-2]) +: 32];
    else      r = {16'h0, line[BEAT_W*int'(sel) +: BEAT_W]};
    return r;
  endfunction
endpackage

// File: rtl/nlb_store.sv
`timescale 1ns/1ps
module nlb_store
  import nlb_pkg::*;
#(
  parameter int unsigned AW = 32,
  localparam int unsigned TAG_W = AW - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_we,
  input  logic [BIDX_W-1:0] beat_idx,
  input  logic [BEAT_W-1:0] beat_data,
  input  logic              fill_begin,
  input  logic              fill_commit,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic              wr_vld,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              line_hit,
  output logic              snoop_hit,
  output logic [LINE_W-1:0] line_data
);
  logic             valid_q;
  logic [TAG_W-1:0] tag_q;

  assign line_hit  = valid_q && (tag_q == look_tag);
  assign snoop_hit = wr_vld && valid_q && (tag_q == wr_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      tag_q     <= '0;
      line_data <= '0;
    end else begin
      if (beat_we) line_data[BEAT_W*int'(beat_idx) +: BEAT_W] <= beat_data;
      if (fill_begin || snoop_hit) valid_q <= 1'b0;
      else if (fill_commit) begin
        valid_q <= 1'b1;
        tag_q   <= fill_tag;
      end
    end
  end

  // R8
  snoop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_hit |=> !valid_q);

  // R5
  valid_after_last_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(beat_we && beat_idx == BIDX_W'(NBEATS-1)));
endmodule

// File: rtl/nlb_seq.sv
`timescale 1ns/1ps
module nlb_seq
  import nlb_pkg::*;
#(
  parameter int unsigned AW = 32,
  localparam int unsigned TAG_W = AW - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [AW-1:0]     cpu_addr,
  input  logic              cpu_wide,
  input  logic              cpu_nobuf,
  input  logic              line_hit,
  input  logic              wr_vld,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              mem_ready,
  input  logic [BEAT_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  output logic              beat_we,
  output logic [BIDX_W-1:0] beat_idx,
  output logic [BEAT_W-1:0] beat_data,
  output logic              fill_begin,
  output logic              fill_commit,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              idle,
  output logic              byp_busy,
  output logic              resp_valid,
  output logic [31:0]       resp_data
);
  sq_state_e         st_q;
  logic [BIDX_W-1:0] beat_q, last_q;
  logic [AW-1:0]     base_q;
  logic              kill_q;
  logic [31:0]       byp_q;

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] base,
                                              input logic [BIDX_W-1:0] k);
    return base + (AW'(k) << 1);
  endfunction

  logic accept, take_fill, take_byp, hs, fill_last, snoop_kill;

  assign idle       = (st_q == SQ_IDLE);
  assign accept     = idle && cpu_req && (cpu_nobuf || !line_hit);
  assign take_fill  = accept && !cpu_nobuf;
  assign take_byp   = accept && cpu_nobuf;
  assign mem_req    = (st_q == SQ_FILL) || (st_q == SQ_BYP);
  assign mem_addr   = beat_addr(base_q, beat_q);
  assign hs         = mem_req && mem_ready;
  assign fill_tag   = base_q[AW-1:OFF_W];
  assign snoop_kill = (st_q == SQ_FILL) && wr_vld && (wr_tag == fill_tag);
  assign fill_last  = (st_q == SQ_FILL) && hs && (beat_q == BIDX_W'(NBEATS-1));
  assign fill_commit = fill_last && !kill_q && !snoop_kill;
  assign fill_begin = take_fill;
  assign beat_we    = (st_q == SQ_FILL) && hs;
  assign beat_idx   = beat_q;
  assign beat_data  = mem_rdata;
  assign byp_busy   = (st_q == SQ_BYP);
  assign resp_valid = (st_q == SQ_RESP);
  assign resp_data  = byp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      beat_q <= '0;
      last_q <= '0;
      base_q <= '0;
      kill_q <= 1'b0;
      byp_q  <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          beat_q <= '0;
          if (take_fill) begin
            base_q <= {cpu_addr[AW-1:OFF_W], OFF_W'(0)};
            kill_q <= 1'b0;
            st_q   <= SQ_FILL;
          end else if (take_byp) begin
            base_q <= cpu_addr & ~AW'(cpu_wide ? 3 : 1);
            last_q <= BIDX_W'(cpu_wide ? 1 : 0);
            byp_q  <= '0;
            st_q   <= SQ_BYP;
          end
        end
        SQ_FILL: begin
          if (snoop_kill) kill_q <= 1'b1;
          if (hs) begin
            beat_q <= beat_q + 1'b1;
            if (fill_last) st_q <= SQ_IDLE;
          end
        end
        SQ_BYP: begin
          if (hs) begin
            byp_q[BEAT_W*int'(beat_q[0]) +: BEAT_W] <= mem_rdata;
            beat_q <= beat_q + 1'b1;
            if (beat_q == last_q) st_q <= SQ_RESP;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // R10
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: rtl/narrow_line_buf.sv
`timescale 1ns/1ps
module narrow_line_buf
  import nlb_pkg::*;
#(
  parameter int unsigned AW = 32,
  localparam int unsigned TAG_W = AW - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [AW-1:0]     cpu_addr,
  input  logic              cpu_wide,
  input  logic              cpu_nobuf,
  output logic              cpu_done,
  output logic [31:0]       cpu_rdata,
  input  logic              wr_vld,
  input  logic [TAG_W-1:0]  wr_line,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_ready,
  input  logic [BEAT_W-1:0] mem_rdata
);
  logic              line_hit, snoop_hit, beat_we, fill_begin, fill_commit;
  logic              seq_idle, byp_busy, resp_valid, hit_done;
  logic [BIDX_W-1:0] beat_idx;
  logic [BEAT_W-1:0] beat_data;
  logic [TAG_W-1:0]  fill_tag;
  logic [LINE_W-1:0] line_data;
  logic [31:0]       resp_data;

  nlb_store #(.AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .beat_we(beat_we), .beat_idx(beat_idx), .beat_data(beat_data),
    .fill_begin(fill_begin), .fill_commit(fill_commit), .fill_tag(fill_tag),
    .wr_vld(wr_vld), .wr_tag(wr_line), .look_tag(cpu_addr[AW-1:OFF_W]),
    .line_hit(line_hit), .snoop_hit(snoop_hit), .line_data(line_data)
  );

  nlb_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_wide(cpu_wide),
    .cpu_nobuf(cpu_nobuf), .line_hit(line_hit),
    .wr_vld(wr_vld), .wr_tag(wr_line),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .beat_we(beat_we), .beat_idx(beat_idx), .beat_data(beat_data),
    .fill_begin(fill_begin), .fill_commit(fill_commit), .fill_tag(fill_tag),
    .idle(seq_idle), .byp_busy(byp_busy),
    .resp_valid(resp_valid), .resp_data(resp_data)
  );

  assign hit_done  = seq_idle && cpu_req && !cpu_nobuf && line_hit;
  assign cpu_done  = hit_done || resp_valid;
  assign cpu_rdata = resp_valid ? resp_data :
                     hit_done   ? pick_data(line_data, cpu_addr[OFF_W-1:1], cpu_wide) :
                                  32'h0;

  // R3
  hit_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_done |-> !mem_req);

  // R7
  bypass_keeps_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byp_busy |=> $stable(line_data));
endmodule

// File: tb/tb_narrow_line_buf.sv
`timescale 1ns/1ps
module tb_narrow_line_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_wide = 1'b0, cpu_nobuf = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        cpu_done;
  logic [31:0] cpu_rdata;
  logic        wr_vld = 1'b0;
  logic [28:0] wr_line = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_rdata = '0;

  narrow_line_buf #(.AW(32)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_wide(cpu_wide), .cpu_nobuf(cpu_nobuf), .cpu_done(cpu_done),
    .cpu_rdata(cpu_rdata), .wr_vld(wr_vld), .wr_line(wr_line),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [15:0] mem [0:255];
  int beats = 0, logn = 0, wcnt = 0;
  logic [31:0] blog [0:15];
  time last_hs_t = 0;

  // 16-bit memory model with 0..2 wait cycles per beat
  always @(negedge clk) begin
    if (mem_req) begin
      if (wcnt == 0) begin
        mem_ready = 1'b1;
        mem_rdata = mem[mem_addr[8:1]];
        blog[logn % 16] = mem_addr;
        logn++;
        beats++;
        last_hs_t = $time;
        wcnt = $urandom_range(0, 2);
      end else begin
        mem_ready = 1'b0;
        wcnt--;
      end
    end else mem_ready = 1'b0;
  end

  function automatic logic [31:0] exp_rd(input logic [31:0] a, input bit wide);
    if (wide) return {mem[{a[8:2], 1'b1}], mem[{a[8:2], 1'b0}]};
    return {16'h0, mem[a[8:1]]};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, input bit wide, input bit nb,
                    input bit snp, input logic [31:0] sa,
                    output logic [31:0] dat, output int nbt, output int waitc,
                    output bit lat_ok);
    int b0;
    @(posedge clk); #1;
    cpu_req = 1'b1; cpu_addr = a; cpu_wide = wide; cpu_nobuf = nb;
    logn = 0; b0 = beats;
    if (snp) begin wr_vld = 1'b1; wr_line = sa[31:3]; end
    waitc = 0;
    forever begin
      @(negedge clk);
      if (cpu_done) break;
      waitc++;
      if (waitc > 300) break;
    end
    dat = cpu_rdata;
    nbt = beats - b0;
    lat_ok = ($time - last_hs_t) == 5;
    if (waitc > 300) chk("read timeout", 32'(waitc), 32'd0);
    @(posedge clk); #1;
    cpu_req = 1'b0; wr_vld = 1'b0;
  endtask

  task automatic snoop(input logic [31:0] a);
    @(posedge clk); #1;
    wr_vld = 1'b1; wr_line = a[31:3];
    @(posedge clk); #1;
    wr_vld = 1'b0;
  endtask

  logic [31:0] d, old;
  int nbt, wc;
  bit lat;

  task automatic t_reset();
    @(negedge clk);
    chk("R1 mem_req in reset", 32'(mem_req), 32'd0);
    chk("R1 cpu_done in reset", 32'(cpu_done), 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_first_miss();
    rd(32'h40, 1, 0, 0, 0, d, nbt, wc, lat);
    chk("R1 first read beats", 32'(nbt), 32'd4);
    chk("R4 miss data", d, exp_rd(32'h40, 1));
    for (int k = 0; k < 4; k++) chk("R2 beat address", blog[k], 32'h40 + 32'(2*k));
    chk("R5 done after last beat", 32'(lat), 32'd1);
  endtask

  task automatic t_hits();
    rd(32'h44, 1, 0, 0, 0, d, nbt, wc, lat);
    chk("R3 hit beats", 32'(nbt), 32'd0);
    chk("R3 hit wait", 32'(wc), 32'd0);
    chk("R4 upper word", d, exp_rd(32'h44, 1));
    rd(32'h42, 0, 0, 0, 0, d, nbt, wc, lat);
    chk("R4 halfword 1", d, exp_rd(32'h42, 0));
    rd(32'h43, 0, 0, 0, 0, d, nbt, wc, lat);
    chk("R4 addr bit0 ignored", d, exp_rd(32'h42, 0));
    rd(32'h46, 0, 0, 0, 0, d, nbt, wc, lat);
    chk("R4 halfword 3", d, exp_rd(32'h46, 0));
    rd(32'h45, 1, 0, 0, 0, d, nbt, wc, lat);
    chk("R4 word low bits ignored", d, exp_rd(32'h44, 1));
    chk("R3 hit beats b", 32'(nbt), 32'd0);
  endtask

  task automatic t_next_line();
    rd(32'h48, 1, 0, 0, 0, d, nbt, wc, lat);
    chk("R6 next line beats", 32'(nbt), 32'd4);
    chk("R6 next line base", blog[0], 32'h48);
    chk("R6 next line data", d, exp_rd(32'h48, 1));
    rd(32'h4C, 1, 0, 0, 0, d, nbt, wc, lat);
    chk("R6 then hit", 32'(nbt), 32'd0);
  endtask

  task automatic t_bypass();
    rd(32'h4B, 0, 1, 0, 0, d, nbt, wc, lat);
    chk("R7 halfword bypass beats", 32'(nbt), 32'd1);
    chk("R7 halfword bypass addr", blog[0], 32'h4A);
    chk("R7 halfword bypass data", d, exp_rd(32'h4A, 0));
    chk("R7 bypass latency", 32'(lat), 32'd1);
    rd(32'h4D, 1, 1, 0, 0, d, nbt, wc, lat);
    chk("R7 word bypass beats", 32'(nbt), 32'd2);
    chk("R7 word bypass addr0", blog[0], 32'h4C);
    chk("R7 word bypass addr1", blog[1], 32'h4E);
    chk("R7 word bypass data", d, exp_rd(32'h4C, 1));
    rd(32'h48, 0, 0, 0, 0, d, nbt, wc, lat);
    chk("R7 line kept", 32'(nbt), 32'd0);
    chk("R7 line kept data", d, exp_rd(32'h48, 0));
  endtask

  task automatic t_snoop_lines();
    snoop(32'h100);
    rd(32'h4C, 1, 0, 0, 0, d, nbt, wc, lat);
    chk("R8 other line no effect", 32'(nbt), 32'd0);
    mem[8'h25] = 16'hBEEF;
    snoop(32'h4A);
    rd(32'h48, 1, 0, 0, 0, d, nbt, wc, lat);
    chk("R8 held line refetched", 32'(nbt), 32'd4);
    chk("R8 new data", d, exp_rd(32'h48, 1));
  endtask

  task automatic t_snoop_same_cycle();
    old = exp_rd(32'h4C, 1);
    mem[8'h27] = 16'h1234;
    rd(32'h4C, 1, 0, 1, 32'h4E, d, nbt, wc, lat);
    chk("R9 same-cycle hit beats", 32'(nbt), 32'd0);
    chk("R9 same-cycle old data", d, old);
    rd(32'h4C, 1, 0, 0, 0, d, nbt, wc, lat);
    chk("R9 after same-cycle miss", 32'(nbt), 32'd4);
    chk("R9 after same-cycle data", d, exp_rd(32'h4C, 1));
  endtask

  task automatic t_snoop_fill();
    fork
      rd(32'h80, 1, 0, 0, 0, d, nbt, wc, lat);
      begin
        @(posedge clk); @(posedge clk); #1;
        mem[8'h42] = 16'hCAFE;
        wr_vld = 1'b1; wr_line = 29'h10;
        @(posedge clk); #1;
        wr_vld = 1'b0;
      end
    join
    chk("R9 fill killed beats", 32'(nbt), 32'd8);
    chk("R9 fill killed data", d, exp_rd(32'h80, 1));
    rd(32'h84, 1, 0, 0, 0, d, nbt, wc, lat);
    chk("R9 refilled hit", 32'(nbt), 32'd0);
    chk("R9 refilled data", d, exp_rd(32'h84, 1));
  endtask

  task automatic t_reset_mid();
    @(posedge clk); #1; rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mem_req in mid reset", 32'(mem_req), 32'd0);
    @(posedge clk); #1; rst_n = 1'b1;
    rd(32'h84, 1, 0, 0, 0, d, nbt, wc, lat);
    chk("R1 miss after reset", 32'(nbt), 32'd4);
    chk("R1 data after reset", d, exp_rd(32'h84, 1));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 257) ^ 16'h3C5A;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_first_miss();
    t_hits();
    t_next_line();
    t_bypass();
    t_snoop_lines();
    t_snoop_same_cycle();
    t_snoop_fill();
    t_reset_mid();
    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=expired expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule